// File: doc/BRIEF.md
# Memory-Region Hazard Scoreboard

This block lets a processor keep executing while a memory-to-memory reconfigurable unit works in the background. Each unit operation reads one memory region and writes another. It names a function and carries a log2 region size. The scoreboard holds up to four operations in flight. It compares every processor load and store, and every newly offered operation, against the regions those operations still own. It stalls whatever would see or disturb data out of program order, so the combined execution behaves as if it were sequential.

Fourteen functions can be loaded into the array. Only four are resident at a time, in a small context cache. An operation whose function is not resident starts a fill request to the context loader and waits for it. Any other operation may retire while the fill is pending. The victim way is the first empty way, and otherwise the least recently used way. Regions are aligned powers of two, so a hazard check is a masked address compare. No data path, memory port or pipeline logic is part of the block.

Top module: `region_scoreboard`

## Requirements
- R1: After reset no slot is busy and no context way is valid. `cpu_stall` and `ld_req` are low, and an offered operation is not ready.
- R2: An operation is accepted at a clock edge where `op_valid` and `op_ready` are both high. It takes the lowest-numbered free slot, reported on `op_tag` in that cycle. There are four slots, and `op_ready` stays low while all four are busy.
- R3: Two regions overlap when their base addresses are equal after clearing the low L bits, where L is the larger of the two log2 sizes. A processor access counts as size 0.
- R4: A processor load (`cpu_we`=0) stalls exactly when it overlaps the destination region of a busy slot. Overlap with a busy source region does not stall it.
- R5: A processor store (`cpu_we`=1) stalls exactly when it overlaps the source or the destination region of a busy slot.
- R6: A new operation is held, with `op_ready` low, in either of two cases. Its source overlaps a busy destination, or its destination overlaps a busy source or destination. Sharing a source with a busy slot does not hold it.
- R7: An operation whose function number is 14 or above, or whose log2 size lies outside 4..12, is never ready and never starts a context fill.
- R8: A pulse on `ret_valid` with `ret_tag` frees that slot at the edge. Stalls and holds caused by that slot clear in the following cycle.
- R9: A legal operation whose function is not resident raises `ld_req` one cycle later. The request gives `ld_func` and a target way on `ld_slot`, and all three hold steady until `ld_done`. While `ld_req` is high no operation is ready.
- R10: The fill target is the lowest-numbered empty way if one exists. Otherwise it is the least recently used way. Both a completed fill and an accepted operation make the way they use the most recently used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | An operation is offered |
| op_func | input | 4 | Function number of the offered operation |
| op_src | input | 16 | Source region base address |
| op_dst | input | 16 | Destination region base address |
| op_lgsz | input | 4 | log2 of region size in address units |
| op_ready | output | 1 | Offered operation can be accepted this cycle |
| op_tag | output | 2 | Slot the accepted operation occupies |
| ret_valid | input | 1 | An in-flight operation finished |
| ret_tag | input | 2 | Slot of the finished operation |
| cpu_valid | input | 1 | Processor memory access present |
| cpu_we | input | 1 | 1 for a store, 0 for a load |
| cpu_addr | input | 16 | Processor access address |
| cpu_stall | output | 1 | Processor access must wait |
| ld_req | output | 1 | Context fill requested |
| ld_func | output | 4 | Function to load |
| ld_slot | output | 2 | Context way to fill |
| ld_done | input | 1 | Requested fill completed |

## Verification
The bench probes addresses on both sides of each region boundary, such as the last byte inside a 256-byte destination and the first byte past it. A design that masks one bit too many or too few would stall on the wrong side. It offers a destination that matches a small busy source only under the larger size's mask. A design using the smaller or the offered size would let that write-after-read through. It also checks that loads from a busy source do not stall while stores to it do. A design with the wrong rule would either lose throughput or corrupt an operand. The LRU sequence loads three functions, reuses the oldest, and then forces a miss. A design that ages ways only on fills, or picks a fixed victim, would evict the wrong context.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
  typedef enum logic {
    CTX_IDLE = 1'b0,
    CTX_FILL = 1'b1
  } ctx_state_e;
endpackage

// File: rtl/rsb_region_cmp.sv
// Aligned power-of-two region overlap: equal above the larger size.
module rsb_region_cmp #(
  parameter int AW  = 16,
  parameter int LGW = 4
) (
  input  logic [AW-1:0]  a,
  input  logic [LGW-1:0] lga,
  input  logic [AW-1:0]  b,
  input  logic [LGW-1:0] lgb,
  output logic           same
);
  logic [LGW-1:0] lgmax;
  logic [AW-1:0]  keep;

  always_comb begin
    lgmax = (lga > lgb) ? lga : lgb;
    keep  = {AW{1'b1}} << lgmax;
    same  = ((a ^ b) & keep) == '0;
  end
endmodule

// File: rtl/rsb_slot_table.sv
// In-flight operation slots and their region hazard comparators.
module rsb_slot_table #(
  parameter int AW    = 16,
  parameter int LGW   = 4,
  parameter int NSLOT = 4,
  parameter int SW    = $clog2(NSLOT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_en,
  input  logic [AW-1:0]    op_src,
  input  logic [AW-1:0]    op_dst,
  input  logic [LGW-1:0]   op_lg,
  input  logic             ret_en,
  input  logic [SW-1:0]    ret_idx,
  input  logic             cpu_valid,
  input  logic             cpu_we,
  input  logic [AW-1:0]    cpu_addr,
  output logic [NSLOT-1:0] busy,
  output logic             full,
  output logic [SW-1:0]    free_idx,
  output logic             cpu_hit,
  output logic             op_hit
);
  logic [NSLOT-1:0] busy_q, busy_d;
  logic [AW-1:0]    src_q [NSLOT];
  logic [AW-1:0]    dst_q [NSLOT];
  logic [LGW-1:0]   lg_q  [NSLOT];
  logic [NSLOT-1:0] cpu_hit_v, op_hit_v;

  always_comb begin
    free_idx = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (!busy_q[i]) free_idx = SW'(i);
    end
    full = &busy_q;
  end

  always_comb begin
    busy_d = busy_q;
    if (ret_en)   busy_d[ret_idx]  = 1'b0;
    if (alloc_en) busy_d[free_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= '0;
    else        busy_q <= busy_d;
  end

  // region descriptors: written only on allocation
  always_ff @(posedge clk) begin
    if (alloc_en) begin
      src_q[free_idx] <= op_src;
      dst_q[free_idx] <= op_dst;
      lg_q[free_idx]  <= op_lg;
    end
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic c_ld, c_st, c_sd, c_ds, c_dd;
    rsb_region_cmp #(.AW(AW), .LGW(LGW)) u_cpu_dst (
      .a(cpu_addr), .lga('0), .b(dst_q[g]), .lgb(lg_q[g]), .same(c_ld));
    rsb_region_cmp #(.AW(AW), .LGW(LGW)) u_cpu_src (
      .a(cpu_addr), .lga('0), .b(src_q[g]), .lgb(lg_q[g]), .same(c_st));
    rsb_region_cmp #(.AW(AW), .LGW(LGW)) u_src_dst (
      .a(op_src), .lga(op_lg), .b(dst_q[g]), .lgb(lg_q[g]), .same(c_sd));
    rsb_region_cmp #(.AW(AW), .LGW(LGW)) u_dst_src (
      .a(op_dst), .lga(op_lg), .b(src_q[g]), .lgb(lg_q[g]), .same(c_ds));
    rsb_region_cmp #(.AW(AW), .LGW(LGW)) u_dst_dst (
      .a(op_dst), .lga(op_lg), .b(dst_q[g]), .lgb(lg_q[g]), .same(c_dd));
    assign cpu_hit_v[g] = busy_q[g] & (c_ld | (cpu_we & c_st));
    assign op_hit_v[g]  = busy_q[g] & (c_sd | c_ds | c_dd);
  end

  assign busy    = busy_q;
  assign cpu_hit = cpu_valid & (|cpu_hit_v);
  assign op_hit  = |op_hit_v;
endmodule

// File: rtl/rsb_ctx_cache.sv
// Resident function contexts with LRU ages and a fill request FSM.
module rsb_ctx_cache
  import rsb_pkg::*;
#(
  parameter int NWAY = 4,
  parameter int FW   = 4,
  parameter int WW   = $clog2(NWAY)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          look_en,
  input  logic [FW-1:0] look_func,
  input  logic          touch_en,
  input  logic          ld_done,
  output logic          hit,
  output logic          fill_busy,
  output logic          ld_req,
  output logic [FW-1:0] ld_func,
  output logic [WW-1:0] ld_slot
);
  logic [FW-1:0]   tag_q [NWAY];
  logic [FW-1:0]   tag_d [NWAY];
  logic [WW-1:0]   age_q [NWAY];
  logic [WW-1:0]   age_d [NWAY];
  logic [NWAY-1:0] tv_q, tv_d, hit_v;
  ctx_state_e      st_q, st_d;
  logic [FW-1:0]   lf_q, lf_d;
  logic [WW-1:0]   ls_q, ls_d;
  logic [WW-1:0]   hit_way, victim, tw;
  logic            tw_en;

  always_comb begin
    hit_way = '0;
    victim  = '0;
    for (int i = 0; i < NWAY; i++) begin
      hit_v[i] = tv_q[i] && (tag_q[i] == look_func);
      if (hit_v[i]) hit_way = WW'(i);
      if (age_q[i] == WW'(NWAY - 1)) victim = WW'(i);
    end
    for (int i = NWAY - 1; i >= 0; i--) begin
      if (!tv_q[i]) victim = WW'(i);
    end
    hit = |hit_v;
  end

  always_comb begin
    tag_d = tag_q;
    tv_d  = tv_q;
    age_d = age_q;
    st_d  = st_q;
    lf_d  = lf_q;
    ls_d  = ls_q;
    tw_en = 1'b0;
    tw    = '0;
    case (st_q)
      CTX_IDLE: begin
        if (look_en && !hit) begin
          st_d = CTX_FILL;
          lf_d = look_func;
          ls_d = victim;
        end else if (touch_en && hit) begin
          tw_en = 1'b1;
          tw    = hit_way;
        end
      end
      default: begin
        if (ld_done) begin
          tag_d[ls_q] = lf_q;
          tv_d[ls_q]  = 1'b1;
          st_d        = CTX_IDLE;
          tw_en       = 1'b1;
          tw          = ls_q;
        end
      end
    endcase
    if (tw_en) begin
      for (int i = 0; i < NWAY; i++) begin
        if (WW'(i) == tw)              age_d[i] = '0;
        else if (age_q[i] < age_q[tw]) age_d[i] = age_q[i] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tv_q <= '0;
      st_q <= CTX_IDLE;
      lf_q <= '0;
      ls_q <= '0;
      for (int i = 0; i < NWAY; i++) begin
        tag_q[i] <= '0;
        age_q[i] <= WW'(i);
      end
    end else begin
      tv_q  <= tv_d;
      st_q  <= st_d;
      lf_q  <= lf_d;
      ls_q  <= ls_d;
      tag_q <= tag_d;
      age_q <= age_d;
    end
  end

  assign fill_busy = (st_q == CTX_FILL);
  assign ld_req    = fill_busy;
  assign ld_func   = lf_q;
  assign ld_slot   = ls_q;
endmodule

// File: rtl/region_scoreboard.sv
module region_scoreboard #(
  parameter int AW     = 16,
  parameter int NSLOT  = 4,
  parameter int NWAY   = 4,
  parameter int NFUNC  = 14,
  parameter int FW     = 4,
  parameter int LGW    = 4,
  parameter int LG_MIN = 4,
  parameter int LG_MAX = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     op_valid,
  input  logic [FW-1:0]            op_func,
  input  logic [AW-1:0]            op_src,
  input  logic [AW-1:0]            op_dst,
  input  logic [LGW-1:0]           op_lgsz,
  output logic                     op_ready,
  output logic [$clog2(NSLOT)-1:0] op_tag,
  input  logic                     ret_valid,
  input  logic [$clog2(NSLOT)-1:0] ret_tag,
  input  logic                     cpu_valid,
  input  logic                     cpu_we,
  input  logic [AW-1:0]            cpu_addr,
  output logic                     cpu_stall,
  output logic                     ld_req,
  output logic [FW-1:0]            ld_func,
  output logic [$clog2(NWAY)-1:0]  ld_slot,
  input  logic                     ld_done
);
  localparam int SW = $clog2(NSLOT);
  localparam int WW = $clog2(NWAY);

  logic             rst_meta, rst_ns;
  logic             legal, accept, full, op_hit, ctx_hit, fill_busy;
  logic [NSLOT-1:0] slot_busy;
  logic [SW-1:0]    free_idx;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_ns, rst_meta} <= 2'b00;
    else        {rst_ns, rst_meta} <= {rst_meta, 1'b1};
  end

  assign legal = (op_func < FW'(NFUNC)) &&
                 (op_lgsz >= LGW'(LG_MIN)) && (op_lgsz <= LGW'(LG_MAX));
  assign op_ready = op_valid & legal & ~full & ~op_hit & ctx_hit & ~fill_busy;
  assign accept   = op_ready;
  assign op_tag   = free_idx;

  rsb_slot_table #(.AW(AW), .LGW(LGW), .NSLOT(NSLOT), .SW(SW)) u_slots (
    .clk      (clk),
    .rst_n    (rst_ns),
    .alloc_en (accept),
    .op_src   (op_src),
    .op_dst   (op_dst),
    .op_lg    (op_lgsz),
    .ret_en   (ret_valid),
    .ret_idx  (ret_tag),
    .cpu_valid(cpu_valid),
    .cpu_we   (cpu_we),
    .cpu_addr (cpu_addr),
    .busy     (slot_busy),
    .full     (full),
    .free_idx (free_idx),
    .cpu_hit  (cpu_stall),
    .op_hit   (op_hit)
  );

  rsb_ctx_cache #(.NWAY(NWAY), .FW(FW), .WW(WW)) u_ctx (
    .clk      (clk),
    .rst_n    (rst_ns),
    .look_en  (op_valid & legal),
    .look_func(op_func),
    .touch_en (accept),
    .ld_done  (ld_done),
    .hit      (ctx_hit),
    .fill_busy(fill_busy),
    .ld_req   (ld_req),
    .ld_func  (ld_func),
    .ld_slot  (ld_slot)
  );
endmodule

// File: rtl/rsb_checker.sv
module rsb_checker #(
  parameter int NSLOT  = 4,
  parameter int NWAY   = 4,
  parameter int NFUNC  = 14,
  parameter int FW     = 4,
  parameter int LGW    = 4,
  parameter int LG_MIN = 4,
  parameter int LG_MAX = 12
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     op_valid,
  input logic                     op_ready,
  input logic [FW-1:0]            op_func,
  input logic [LGW-1:0]           op_lgsz,
  input logic [$clog2(NSLOT)-1:0] op_tag,
  input logic                     ret_valid,
  input logic [$clog2(NSLOT)-1:0] ret_tag,
  input logic                     cpu_valid,
  input logic                     cpu_stall,
  input logic                     ld_req,
  input logic [FW-1:0]            ld_func,
  input logic [$clog2(NWAY)-1:0]  ld_slot,
  input logic                     ld_done,
  input logic [NSLOT-1:0]         busy
);
  AST_SLOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_ready |=> busy[$past(op_tag)]); // R2
  AST_TAG_IS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    op_ready |-> !busy[op_tag]); // R2
  AST_STALL_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_stall |-> cpu_valid); // R4
  AST_LEGAL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    op_ready |-> (op_func < FW'(NFUNC)) && (op_lgsz >= LGW'(LG_MIN)) && (op_lgsz <= LGW'(LG_MAX))); // R7
  AST_RETIRE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid && !(op_valid && op_ready) |=> !busy[$past(ret_tag)]); // R8
  AST_FILL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ld_req && !ld_done |=> ld_req && $stable(ld_func) && $stable(ld_slot)); // R9
  AST_FILL_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    ld_req && ld_done |=> !ld_req); // R9
  AST_NO_ACCEPT_IN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    ld_req |-> !op_ready); // R9
endmodule

bind region_scoreboard rsb_checker #(
  .NSLOT(NSLOT), .NWAY(NWAY), .NFUNC(NFUNC), .FW(FW), .LGW(LGW),
  .LG_MIN(LG_MIN), .LG_MAX(LG_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_ns), .op_valid(op_valid), .op_ready(op_ready),
  .op_func(op_func), .op_lgsz(op_lgsz), .op_tag(op_tag),
  .ret_valid(ret_valid), .ret_tag(ret_tag), .cpu_valid(cpu_valid),
  .cpu_stall(cpu_stall), .ld_req(ld_req), .ld_func(ld_func),
  .ld_slot(ld_slot), .ld_done(ld_done), .busy(slot_busy)
);

// File: tb/sim_region_scoreboard.sv
module sim_region_scoreboard;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid, op_ready;
  logic [3:0]  op_func, op_lgsz;
  logic [15:0] op_src, op_dst;
  logic [1:0]  op_tag, ret_tag, ld_slot;
  logic        ret_valid, cpu_valid, cpu_we, cpu_stall, ld_req, ld_done;
  logic [15:0] cpu_addr;
  logic [3:0]  ld_func;

  int nvec = 0;
  int nerr = 0;

  always #5 clk = ~clk;

  region_scoreboard u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_func(op_func),
    .op_src(op_src), .op_dst(op_dst), .op_lgsz(op_lgsz), .op_ready(op_ready),
    .op_tag(op_tag), .ret_valid(ret_valid), .ret_tag(ret_tag),
    .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_stall(cpu_stall), .ld_req(ld_req), .ld_func(ld_func),
    .ld_slot(ld_slot), .ld_done(ld_done)
  );

  // {kind(0 load,1 store,2 op), func, a(addr/src), b(dst), lgsz, expected}
  // probed with slot0 = src 1000/dst 2000 lg8, slot1 = src 3000/dst 4000 lg12
  localparam int NV = 22;
  localparam logic [42:0] VEC [NV] = '{
    {2'd0, 4'd0, 16'h2080, 16'h0000, 4'd0,  1'b1},
    {2'd0, 4'd0, 16'h1080, 16'h0000, 4'd0,  1'b0},
    {2'd1, 4'd0, 16'h1080, 16'h0000, 4'd0,  1'b1},
    {2'd1, 4'd0, 16'h2000, 16'h0000, 4'd0,  1'b1},
    {2'd0, 4'd0, 16'h2100, 16'h0000, 4'd0,  1'b0},
    {2'd0, 4'd0, 16'h20FF, 16'h0000, 4'd0,  1'b1},
    {2'd0, 4'd0, 16'h4FFF, 16'h0000, 4'd0,  1'b1},
    {2'd1, 4'd0, 16'h3ABC, 16'h0000, 4'd0,  1'b1},
    {2'd0, 4'd0, 16'h3ABC, 16'h0000, 4'd0,  1'b0},
    {2'd1, 4'd0, 16'h5000, 16'h0000, 4'd0,  1'b0},
    {2'd0, 4'd0, 16'h0FFF, 16'h0000, 4'd0,  1'b0},
    {2'd1, 4'd0, 16'h1100, 16'h0000, 4'd0,  1'b0},
    {2'd2, 4'd2, 16'h2040, 16'h6000, 4'd4,  1'b0},
    {2'd2, 4'd2, 16'h6000, 16'h10F0, 4'd4,  1'b0},
    {2'd2, 4'd2, 16'h6000, 16'h4800, 4'd4,  1'b0},
    {2'd2, 4'd2, 16'h1000, 16'h6000, 4'd8,  1'b1},
    {2'd2, 4'd2, 16'h6000, 16'h2100, 4'd8,  1'b1},
    {2'd2, 4'd2, 16'h6000, 16'h7000, 4'd12, 1'b1},
    {2'd2, 4'd2, 16'h6000, 16'h1800, 4'd12, 1'b0},
    {2'd2, 4'd2, 16'h6000, 16'h7000, 4'd3,  1'b0},
    {2'd2, 4'd2, 16'h6000, 16'h7000, 4'd13, 1'b0},
    {2'd2, 4'd14, 16'h6000, 16'h7000, 4'd4, 1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic probe_cpu(input logic we, input logic [15:0] a, output int st);
    @(negedge clk);
    cpu_valid = 1'b1; cpu_we = we; cpu_addr = a;
    #1 st = int'(cpu_stall);
    cpu_valid = 1'b0;
  endtask

  task automatic probe_op(input logic [3:0] f, input logic [15:0] s, input logic [15:0] d,
                          input logic [3:0] lg, output int rdy);
    @(negedge clk);
    op_valid = 1'b1; op_func = f; op_src = s; op_dst = d; op_lgsz = lg;
    #1 rdy = int'(op_ready);
    op_valid = 1'b0;
  endtask

  task automatic issue(input logic [3:0] f, input logic [15:0] s, input logic [15:0] d,
                       input logic [3:0] lg, output int tag, output int lslot);
    bit done = 1'b0;
    tag = -1; lslot = -1;
    @(negedge clk);
    op_valid = 1'b1; op_func = f; op_src = s; op_dst = d; op_lgsz = lg;
    #1;
    for (int guard = 0; guard < 40 && !done; guard++) begin
      if (op_ready) begin
        tag = int'(op_tag);
        @(posedge clk); #1;
        done = 1'b1;
      end else if (ld_req) begin
        lslot = int'(ld_slot);
        ld_done = 1'b1;
        @(posedge clk); #1;
        ld_done = 1'b0;
        @(negedge clk); #1;
      end else begin
        @(negedge clk); #1;
      end
    end
    op_valid = 1'b0;
  endtask

  task automatic retire(input int t);
    @(negedge clk);
    ret_valid = 1'b1; ret_tag = 2'(t);
    @(posedge clk); #1;
    ret_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    nerr++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    int r, tg, ls;
    rst_n = 1'b0; op_valid = 1'b0; op_func = '0; op_src = '0; op_dst = '0;
    op_lgsz = 4'd4; ret_valid = 1'b0; ret_tag = '0; cpu_valid = 1'b0;
    cpu_we = 1'b0; cpu_addr = '0; ld_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    check("R1 ld_req", int'(ld_req), 0);
    probe_cpu(1'b1, 16'h2080, r); check("R1 cpu_stall", r, 0);
    probe_op(4'd2, 16'h1000, 16'h2000, 4'd8, r); check("R1 op_ready (no context)", r, 0);

    // R9/R10: first miss fills way 0, then accepted in slot 0
    issue(4'd2, 16'h1000, 16'h2000, 4'd8, tg, ls);
    check("R10 first fill way", ls, 0);
    check("R2 first tag", tg, 0);
    issue(4'd2, 16'h3000, 16'h4000, 4'd12, tg, ls);
    check("R10 resident hit no fill", ls, -1);
    check("R2 second tag", tg, 1);

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  k;
      logic [3:0]  f, lg;
      logic [15:0] a, b;
      logic        e;
      {k, f, a, b, lg, e} = VEC[i];
      if (k == 2'd2) begin
        probe_op(f, a, b, lg, r);
        check($sformatf("R3/R6/R7 op hold vec %0d", i), r, int'(e));
      end else if (k == 2'd1) begin
        probe_cpu(1'b1, a, r);
        check($sformatf("R3/R5 store vec %0d", i), r, int'(e));
      end else begin
        probe_cpu(1'b0, a, r);
        check($sformatf("R3/R4 load vec %0d", i), r, int'(e));
      end
    end

    // R2: fill all slots
    issue(4'd2, 16'h8000, 16'h9000, 4'd4, tg, ls); check("R2 third tag", tg, 2);
    issue(4'd2, 16'hA000, 16'hB000, 4'd4, tg, ls); check("R2 fourth tag", tg, 3);
    probe_op(4'd2, 16'hC000, 16'hD000, 4'd4, r); check("R2 full holds", r, 0);

    // R8: retire releases stall and slot
    probe_cpu(1'b0, 16'h2080, r); check("R8 before retire", r, 1);
    retire(0);
    probe_cpu(1'b0, 16'h2080, r); check("R8 after retire", r, 0);
    probe_op(4'd2, 16'hC000, 16'hD000, 4'd4, r); check("R2 slot freed", r, 1);
    retire(1); retire(2); retire(3);

    // R10: LRU order
    issue(4'd5, 16'h0100, 16'h0200, 4'd4, tg, ls); check("R10 fill way1", ls, 1);
    check("R2 lowest free tag", tg, 0); retire(tg);
    issue(4'd7, 16'h0100, 16'h0200, 4'd4, tg, ls); check("R10 fill way2", ls, 2); retire(tg);
    issue(4'd9, 16'h0100, 16'h0200, 4'd4, tg, ls); check("R10 fill way3", ls, 3); retire(tg);
    issue(4'd2, 16'h0100, 16'h0200, 4'd4, tg, ls); check("R10 hit refresh", ls, -1); retire(tg);
    issue(4'd11, 16'h0100, 16'h0200, 4'd4, tg, ls); check("R10 evict LRU way1", ls, 1); retire(tg);

    // R7: illegal function never fills
    @(negedge clk);
    op_valid = 1'b1; op_func = 4'd14; op_src = 16'h0100; op_dst = 16'h0200; op_lgsz = 4'd4;
    repeat (3) @(negedge clk);
    check("R7 illegal func no fill", int'(ld_req), 0);
    check("R7 illegal func not ready", int'(op_ready), 0);
    op_valid = 1'b0;

    // R9: request held without ld_done; R10 victim now way2
    @(negedge clk);
    op_valid = 1'b1; op_func = 4'd13; op_src = 16'h0100; op_dst = 16'h0200; op_lgsz = 4'd4;
    repeat (3) @(negedge clk);
    check("R9 request held", int'(ld_req), 1);
    check("R9 ld_func", int'(ld_func), 13);
    check("R10 ld_slot after reuse", int'(ld_slot), 2);
    check("R9 not ready during fill", int'(op_ready), 0);
    ld_done = 1'b1;
    @(negedge clk);
    ld_done = 1'b0;
    check("R9 request dropped", int'(ld_req), 0);
    check("R9 ready after fill", int'(op_ready), 1);
    op_valid = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule